// File: doc/BRIEF.md
# Division Overflow Predictor

This block decides, before any divide hardware starts, whether a division will fail to give a representable result. It handles two operand shapes: a short form, where a 32-bit dividend is divided by a 32-bit divisor, and a long form, where a 64-bit dividend is divided by a 32-bit divisor and both quotient and remainder must fit in 32 bits. Either shape may treat the operands as two's complement or as unsigned. A zero divisor always counts as an error, so 0 ÷ 0 is flagged as well.

For the signed long form the block performs no division. It takes the absolute values of both operands and makes one unsigned magnitude comparison. When the operand signs agree, the dividend magnitude must stay below the divisor magnitude shifted left by 31. When the signs differ, the divisor magnitude is also added to that bound, because a negative quotient may reach −2^31. The flag is registered, so the verdict for the operands on the ports appears one clock later. The divider, or trap logic next to it, uses the flag to decide whether to start the operation.

Top module: `divovf_predictor`

## Requirements
- R1: With `mode_long_i`=0 and `is_signed_i`=1, the flag is 1 exactly when the divisor is 0, or when `dividend_i[31:0]` is 0x80000000 and the divisor is 0xFFFFFFFF.
- R2: With `mode_long_i`=0 and `is_signed_i`=0, the flag is 1 exactly when the divisor is 0.
- R3: A zero dividend divided by a zero divisor raises the flag in all four mode and sign combinations.
- R4: With `mode_long_i`=0, `dividend_i[63:32]` has no effect on the flag.
- R5: With `mode_long_i`=1 and `is_signed_i`=0, the flag is 1 exactly when the divisor is 0 or `dividend_i[63:32]` is greater than or equal to the divisor, both compared as unsigned.
- R6: With `mode_long_i`=1 and `is_signed_i`=1, the flag is 1 exactly when the divisor is 0, or the quotient, truncated toward zero, lies outside −2^31 to 2^31−1. This holds at both edges of that range, for either sign of the quotient.
- R7: With `mode_long_i`=1 and `is_signed_i`=1, a dividend of 0x8000000000000000 raises the flag for every divisor.
- R8: `ovf_o` shows the verdict for the inputs sampled at the previous rising clock edge. It does not change between edges.
- R9: While the synchronous active-high reset `rst_i` is sampled high, `ovf_o` is 0 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mode_long_i | input | 1 | 0: 32/32 division, 1: 64/32 long division |
| is_signed_i | input | 1 | 1: operands are two's complement, 0: unsigned |
| dividend_i | input | 64 | Dividend; only bits 31:0 are used in short mode |
| divisor_i | input | 32 | Divisor |
| ovf_o | output | 1 | Registered overflow / divide-error flag |

## Verification
Every fault in this block shows up at the ports one clock after the offending operands are presented, because only the output register stands between the inputs and `ovf_o`. A wrong magnitude from the absolute-value stage, or a bound that is off by one divisor, appears only near the quotient limits. The directed cases therefore place quotients exactly at −2^31, at 2^31−1 and one step beyond each. The extreme dividends and the divisors 0, ±1 and the most negative value expose sign-handling faults that ordinary operands would hide.

// File: rtl/divovf_pkg.sv
package divovf_pkg;

    // Operand shape selected by mode_long_i
    typedef enum logic {
        DIV_SHORT = 1'b0,
        DIV_LONG  = 1'b1
    } div_width_e;

    // Per-operation error reasons, combined into the single flag
    typedef struct packed {
        logic zero_div;
        logic range_err;
    } verdict_t;

    function automatic logic verdict_flag(input verdict_t v);
        return v.zero_div | v.range_err;
    endfunction

    function automatic verdict_t make_verdict(input logic zdiv, input logic rerr);
        verdict_t v;
        v.zero_div  = zdiv;
        v.range_err = rerr;
        return v;
    endfunction

endpackage

// File: rtl/divovf_magnitude.sv
module divovf_magnitude #(
    parameter int W = 32
) (
    input  logic         as_signed_i,
    input  logic [W-1:0] value_i,
    output logic         neg_o,
    output logic [W-1:0] mag_o
);
    // The most negative value maps to 2^(W-1), which is exact as unsigned
    always_comb begin
        neg_o = as_signed_i & value_i[W-1];
        mag_o = neg_o ? (~value_i + {{(W-1){1'b0}}, 1'b1}) : value_i;
    end
endmodule

// File: rtl/divovf_short_check.sv
module divovf_short_check #(
    parameter int W = 32
) (
    input  logic         as_signed_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         range_err_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MINUS_ONE = {W{1'b1}};

    logic dvd_is_min;
    logic dvs_is_m1;

    always_comb begin
        dvd_is_min  = (dividend_i == MOST_NEG);
        dvs_is_m1   = (divisor_i == MINUS_ONE);
        range_err_o = as_signed_i & dvd_is_min & dvs_is_m1;
    end
endmodule

// File: rtl/divovf_long_check.sv
module divovf_long_check #(
    parameter int W = 32
) (
    input  logic           as_signed_i,
    input  logic           signs_differ_i,
    input  logic [2*W-1:0] dvd_mag_i,
    input  logic [W-1:0]   dvs_mag_i,
    output logic           range_err_o
);
    localparam int BW = 2*W + 1;

    logic [BW-1:0] dvd_ext;
    logic [BW-1:0] dvs_ext;
    logic [BW-1:0] bound_same;
    logic [BW-1:0] bound_diff;
    logic [BW-1:0] bound_sel;
    logic          uns_err;
    logic          sgn_err;

    always_comb begin
        dvd_ext    = {1'b0, dvd_mag_i};
        dvs_ext    = {{(W+1){1'b0}}, dvs_mag_i};
        // Non-negative quotient limit: 2^(W-1)-1, so |x| < |y| * 2^(W-1)
        bound_same = dvs_ext << (W-1);
        // Negative quotient may reach -2^(W-1): |x| < |y| * (2^(W-1) + 1)
        bound_diff = bound_same + dvs_ext;
        bound_sel  = signs_differ_i ? bound_diff : bound_same;
        sgn_err    = !(dvd_ext < bound_sel);
        // Unsigned: quotient fits in W bits iff upper half < divisor
        uns_err    = (dvd_mag_i[2*W-1:W] >= dvs_mag_i);
        range_err_o = as_signed_i ? sgn_err : uns_err;
    end
endmodule

// File: rtl/divovf_predictor.sv
module divovf_predictor
    import divovf_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  logic           mode_long_i,
    input  logic           is_signed_i,
    input  logic [2*W-1:0] dividend_i,
    input  logic [W-1:0]   divisor_i,
    output logic           ovf_o
);
    localparam int DW = 2*W;
    localparam logic [DW-1:0] DVD_MOST_NEG = {1'b1, {(DW-1){1'b0}}};
    localparam logic [W-1:0]  SHORT_MOST_NEG = {1'b1, {(W-1){1'b0}}};

    div_width_e width_sel;
    logic       dvd_neg;
    logic       dvs_neg;
    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;
    logic       divisor_zero;
    logic       short_err;
    logic       long_err;
    verdict_t   verdict;
    logic       ovf_q;

    assign width_sel = div_width_e'(mode_long_i);

    divovf_magnitude #(.W(DW)) u_dvd_mag (
        .as_signed_i (is_signed_i),
        .value_i     (dividend_i),
        .neg_o       (dvd_neg),
        .mag_o       (dvd_mag)
    );

    divovf_magnitude #(.W(W)) u_dvs_mag (
        .as_signed_i (is_signed_i),
        .value_i     (divisor_i),
        .neg_o       (dvs_neg),
        .mag_o       (dvs_mag)
    );

    divovf_short_check #(.W(W)) u_short (
        .as_signed_i (is_signed_i),
        .dividend_i  (dividend_i[W-1:0]),
        .divisor_i   (divisor_i),
        .range_err_o (short_err)
    );

    divovf_long_check #(.W(W)) u_long (
        .as_signed_i    (is_signed_i),
        .signs_differ_i (dvd_neg ^ dvs_neg),
        .dvd_mag_i      (dvd_mag),
        .dvs_mag_i      (dvs_mag),
        .range_err_o    (long_err)
    );

    always_comb begin
        divisor_zero = (divisor_i == '0);
        unique case (width_sel)
            DIV_SHORT: verdict = make_verdict(divisor_zero, short_err);
            DIV_LONG:  verdict = make_verdict(divisor_zero, long_err);
            default:   verdict = make_verdict(1'b1, 1'b0);
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ovf_q <= 1'b0;
        else       ovf_q <= verdict_flag(verdict);
    end

    assign ovf_o = ovf_q;

    AST_ZERO_BY_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (divisor_i == '0 && dividend_i == '0) |=> ovf_o); // R3
    AST_SHORT_MIN_BY_M1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_long_i && is_signed_i && dividend_i[W-1:0] == SHORT_MOST_NEG
         && divisor_i == '1) |=> ovf_o); // R1
    AST_SHORT_UNS_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        (!mode_long_i && !is_signed_i && divisor_i != '0) |=> !ovf_o); // R2
    AST_LONG_UNS_FITS: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_long_i && !is_signed_i && divisor_i != '0
         && dividend_i[DW-1:W] < divisor_i) |=> !ovf_o); // R5
    AST_LONG_MOST_NEG: assert property (@(posedge clk_i) disable iff (rst_i)
        (mode_long_i && is_signed_i && dividend_i == DVD_MOST_NEG) |=> ovf_o); // R7
    AST_RESET_CLEARS: assert property (@(posedge clk_i)
        rst_i |=> !ovf_o); // R9
endmodule

// File: tb/divovf_predictor_tb.sv
module divovf_predictor_tb_top;
    localparam int W = 32;

    logic          clk_i = 1'b0;
    logic          rst_i = 1'b1;
    logic          mode_long_i = 1'b0;
    logic          is_signed_i = 1'b0;
    logic [63:0]   dividend_i = '0;
    logic [31:0]   divisor_i = 32'd1;
    logic          ovf_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk_i = ~clk_i;   // 250 MHz

    divovf_predictor #(.W(W)) dut_i (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mode_long_i (mode_long_i),
        .is_signed_i (is_signed_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .ovf_o       (ovf_o)
    );

    // Reference: exact wide division, then range check of the quotient
    function automatic logic ref_ovf(input logic lng, input logic sgn,
                                     input logic [63:0] x, input logic [31:0] y);
        logic signed [127:0] n;
        logic signed [127:0] d;
        logic signed [127:0] q;
        if (y == 0) return 1'b1;
        if (lng) n = sgn ? {{64{x[63]}}, x} : {64'd0, x};
        else     n = sgn ? {{96{x[31]}}, x[31:0]} : {96'd0, x[31:0]};
        d = sgn ? {{96{y[31]}}, y} : {96'd0, y};
        q = n / d;
        if (sgn) return (q > $signed(128'h7FFF_FFFF)) || (q < -$signed(128'h8000_0000));
        return q > $signed(128'hFFFF_FFFF);
    endfunction

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: ovf_o=%0b expected=%0b", req, got, exp);
        end
    endtask

    // Drive at negedge, sample at the following negedge (after one rising edge)
    task automatic run_case(input string req, input logic lng, input logic sgn,
                            input logic [63:0] x, input logic [31:0] y);
        @(negedge clk_i);
        mode_long_i = lng; is_signed_i = sgn; dividend_i = x; divisor_i = y;
        @(negedge clk_i);
        check(req, ovf_o, ref_ovf(lng, sgn, x, y));
    endtask

    task automatic t_reset;
        @(negedge clk_i);
        rst_i = 1'b1; mode_long_i = 0; is_signed_i = 0; divisor_i = 0; dividend_i = 0;
        @(negedge clk_i);
        check("R9", ovf_o, 1'b0);
        @(negedge clk_i);
        check("R9", ovf_o, 1'b0);
        rst_i = 1'b0;
    endtask

    task automatic t_short_signed;
        run_case("R1", 0, 1, 64'h0000_0000_8000_0000, 32'hFFFF_FFFF);
        check("R1", ovf_o, 1'b1);
        run_case("R1", 0, 1, 64'h0000_0000_8000_0000, 32'h0000_0001);
        run_case("R1", 0, 1, 64'h0000_0000_7FFF_FFFF, 32'hFFFF_FFFF);
        run_case("R1", 0, 1, 64'h0000_0000_8000_0000, 32'h8000_0000);
        run_case("R1", 0, 1, 64'h0000_0000_1234_5678, 32'h0000_0000);
    endtask

    task automatic t_short_unsigned;
        run_case("R2", 0, 0, 64'h0000_0000_8000_0000, 32'hFFFF_FFFF);
        run_case("R2", 0, 0, 64'h0000_0000_FFFF_FFFF, 32'h0000_0001);
        run_case("R2", 0, 0, 64'h0000_0000_0000_0005, 32'h0000_0000);
        check("R2", ovf_o, 1'b1);
    endtask

    task automatic t_zero_by_zero;
        for (int m = 0; m < 4; m++) begin
            run_case("R3", m[1], m[0], 64'd0, 32'd0);
            check("R3", ovf_o, 1'b1);
        end
    endtask

    task automatic t_upper_ignored;
        // Upper half would overflow in long mode; short mode must not care
        run_case("R4", 0, 0, 64'hFFFF_FFFF_0000_0010, 32'h0000_0003);
        check("R4", ovf_o, 1'b0);
        run_case("R4", 0, 1, 64'h8000_0000_7FFF_FFFF, 32'hFFFF_FFFF);
        check("R4", ovf_o, 1'b0);
    endtask

    task automatic t_long_unsigned;
        run_case("R5", 1, 0, 64'h0000_0004_FFFF_FFFF, 32'h0000_0005);
        check("R5", ovf_o, 1'b0);
        run_case("R5", 1, 0, 64'h0000_0005_0000_0000, 32'h0000_0005);
        check("R5", ovf_o, 1'b1);
        run_case("R5", 1, 0, 64'hFFFF_FFFE_FFFF_FFFF, 32'hFFFF_FFFF);
        run_case("R5", 1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0000_0000);
    endtask

    task automatic t_long_signed;
        run_case("R6", 1, 1, 64'hFFFF_FFFF_8000_0000, 32'h0000_0001);   // -2^31
        check("R6", ovf_o, 1'b0);
        run_case("R6", 1, 1, 64'h0000_0000_8000_0000, 32'h0000_0001);   // +2^31
        check("R6", ovf_o, 1'b1);
        run_case("R6", 1, 1, 64'h0000_0000_8000_0000, 32'hFFFF_FFFF);   // -2^31
        check("R6", ovf_o, 1'b0);
        run_case("R6", 1, 1, 64'hFFFF_FFFF_8000_0000, 32'hFFFF_FFFF);   // +2^31
        check("R6", ovf_o, 1'b1);
        run_case("R6", 1, 1, 64'h0000_0003_8000_0006, 32'hFFFF_FFF9);   // q=-2^31
        check("R6", ovf_o, 1'b0);
        run_case("R6", 1, 1, 64'h0000_0003_8000_0007, 32'hFFFF_FFF9);   // q=-2^31-1
        check("R6", ovf_o, 1'b1);
        run_case("R6", 1, 1, 64'h0000_0003_7FFF_FFFF, 32'h0000_0007);
        run_case("R6", 1, 1, 64'h3FFF_FFFF_FFFF_FFFF, 32'h8000_0000);
        run_case("R6", 1, 1, 64'hC000_0000_0000_0000, 32'h8000_0000);
        run_case("R6", 1, 1, 64'h0000_0000_0000_0000, 32'h8000_0000);
        for (int i = 0; i < 40; i++) begin
            logic [63:0] x;
            logic [31:0] y;
            x = {32'(i * 32'h9E37_79B9) >> (i % 32), 32'(i * 32'h85EB_CA6B)};
            y = 32'(i * 32'hC2B2_AE35) >> (i % 31);
            if (i[0]) x = ~x;
            run_case("R6", 1, 1, x, y);
        end
    endtask

    task automatic t_most_neg;
        run_case("R7", 1, 1, 64'h8000_0000_0000_0000, 32'hFFFF_FFFF);
        check("R7", ovf_o, 1'b1);
        run_case("R7", 1, 1, 64'h8000_0000_0000_0000, 32'h8000_0000);
        check("R7", ovf_o, 1'b1);
        run_case("R7", 1, 1, 64'h8000_0000_0000_0000, 32'h0000_0001);
        check("R7", ovf_o, 1'b1);
    endtask

    task automatic t_latency;
        run_case("R8", 0, 0, 64'd9, 32'd3);
        @(negedge clk_i);
        divisor_i = 32'd0;
        #1;
        check("R8", ovf_o, 1'b0);      // not yet clocked
        @(negedge clk_i);
        check("R8", ovf_o, 1'b1);      // one edge later
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        t_short_signed();
        t_short_unsigned();
        t_zero_by_zero();
        t_upper_ignored();
        t_long_unsigned();
        t_long_signed();
        t_most_neg();
        t_latency();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule